// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block is the command path of a memory-mapped SD host controller. Host software programs a 32-bit argument and then writes a command word. A write whose start bit is set queues the command. The block then offers the 6-bit index and the argument to a simplified card-side port with a valid/ready handshake, and waits for one response beat. The response beat carries a byte count, an error bit and up to 16 bytes.

The response length is checked against the no-response and long-response flags of the command. A good response is unpacked into four 32-bit response registers. A bad response, or a card error, raises a fail flag in the command word and a timeout bit in a write-one-to-clear status register. A successful busy-wait command can raise a busy interrupt, and a level interrupt output follows the interrupt bits of the status register. Only one command is outstanding at a time. A command written while the card side is busy is held and issued once the card side is free, and a busy output shows the host that work is queued or in flight.

Top module: `sd_cmd_path`

## Requirements
- R1: Writing offset 0x00 with bit 15 set presents `card_req_o` with `card_idx_o` equal to bits 5:0 of the word and `card_arg_o` equal to the argument register (offset 0x04). One cycle after the handshake (`card_req_o` and `card_ready_i` both high), the command word reads back with bit 15 clear and every other written bit unchanged.
- R2: While `card_ready_i` is low, or while a previous command is still waiting for its response, the request is held pending and `busy_o` is high. A command written while one is outstanding is requested, with its own index, in the cycle after the outstanding response arrives. `busy_o` falls in the cycle after the last response.
- R3: A command with bit 10 set (no response) completes without failure whatever the returned length, and leaves the response registers unchanged.
- R4: A successful 4-byte response puts byte 0 in bits 31:24 of response register 0 (offset 0x10), down to byte 3 in bits 7:0, and clears response registers 1 to 3 (0x14, 0x18, 0x1C). Response byte k arrives on `card_rsp_data_i[127-8k -: 8]`.
- R5: A successful 16-byte response fills response register i (offset 0x10+4i) from bytes 12-4i to 15-4i, each word with its lowest-numbered byte in bits 31:24. So register 3 holds bytes 0 to 3 and register 0 holds bytes 12 to 15.
- R6: When bit 10 of the command is clear, a returned length of 0, a length of 4 while bit 9 (long) is set, or any length other than 4 or 16 is a failure. A failure sets command word bit 14 and status bit 6 (offset 0x20), and leaves the response registers unchanged.
- R7: A card error (`card_rsp_err_i`) is a failure even when bit 10 of the command is set.
- R8: A successful command with bit 11 (busy-wait) set, completing while configuration bit 10 (offset 0x24) is set, sets status bit 10. With configuration bit 10 clear, status bit 10 stays clear. `irq_o` is high exactly while any of status bits 10, 9 or 8 is set.
- R9: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: Reads return the command word (16 bits), the argument, the response registers, the status (11 bits) and the configuration (11 bits, read back as written) at their offsets. Any other offset reads zero.
- R11: A response beat that arrives while no command is waiting for it changes no register and raises no interrupt.
- R12: After reset all registers read zero, and `busy_o`, `irq_o` and `card_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the offset |
| card_req_o | output | 1 | Command request valid |
| card_ready_i | input | 1 | Card side accepts the request |
| card_idx_o | output | 6 | Command index |
| card_arg_o | output | 32 | Command argument |
| card_rsp_valid_i | input | 1 | Response beat valid |
| card_rsp_err_i | input | 1 | Card reports a command error |
| card_rsp_len_i | input | LEN_W | Response length in bytes |
| card_rsp_data_i | input | 128 | Response bytes, byte 0 in the top byte |
| busy_o | output | 1 | Command pending or outstanding |
| irq_o | output | 1 | Level interrupt |

## Verification
A register write takes effect at the clock edge that samples it. `card_req_o` is therefore visible in the next cycle when the card side is idle. The cleared start bit appears one cycle after the handshake edge. Response registers, status, the fail flag, `irq_o` and the fall of `busy_o` all change at the edge that samples the response beat. The bench drives every input on a falling edge and samples each result on the falling edge after the rising edge that is due to produce it. Reads are combinational, so they are taken one time step after the offset is set.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam logic [7:0] OFF_CMD  = 8'h00;
  localparam logic [7:0] OFF_ARG  = 8'h04;
  localparam logic [7:0] OFF_RSP0 = 8'h10;
  localparam logic [7:0] OFF_STS  = 8'h20;
  localparam logic [7:0] OFF_CFG  = 8'h24;

  localparam int unsigned CMD_W       = 16;
  localparam int unsigned IDX_W       = 6;
  localparam int unsigned BIT_NEW     = 15;
  localparam int unsigned BIT_FAIL    = 14;
  localparam int unsigned BIT_BUSYW   = 11;
  localparam int unsigned BIT_NORSP   = 10;
  localparam int unsigned BIT_LONG    = 9;

  localparam int unsigned STS_W       = 11;
  localparam int unsigned STS_BUSYIRQ = 10;
  localparam int unsigned STS_TOUT    = 6;
  localparam int unsigned CFG_W       = 11;
  localparam int unsigned CFG_BUSYIE  = 10;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_WAIT = 1'b1} seq_state_e;

  typedef struct packed {
    logic busyw;
    logic norsp;
    logic longr;
  } cmd_flags_t;
endpackage

// File: rtl/sd_rsp_check.sv
module sd_rsp_check
  import sd_cmd_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RSP_WORDS = 4,
  parameter int unsigned LEN_W     = 5
) (
  input  cmd_flags_t                         flags_i,
  input  logic                               err_i,
  input  logic [LEN_W-1:0]                   len_i,
  input  logic [RSP_WORDS*DATA_W-1:0]        data_i,
  output logic                               fail_o,
  output logic                               store_o,
  output logic [RSP_WORDS-1:0][DATA_W-1:0]   words_o
);
  localparam int unsigned RSP_BITS = RSP_WORDS * DATA_W;
  localparam int unsigned SHORT_B  = DATA_W / 8;
  localparam int unsigned LONG_B   = RSP_BITS / 8;

  logic len_short, len_long, shape_bad;

  assign len_short = (len_i == LEN_W'(SHORT_B));
  assign len_long  = (len_i == LEN_W'(LONG_B));
  assign shape_bad = (len_i == '0) | (len_short & flags_i.longr) | (!len_short & !len_long);
  assign fail_o    = err_i | (!flags_i.norsp & shape_bad);
  assign store_o   = !fail_o & !flags_i.norsp;

  // long: word i takes bytes (N-4-4i)..(N-1-4i); short: word 0 takes bytes 0..3
  for (genvar i = 0; i < RSP_WORDS; i++) begin : g_word
    if (i == 0) begin : g_first
      assign words_o[i] = len_short ? data_i[RSP_BITS-1 -: DATA_W] : data_i[DATA_W-1:0];
    end else begin : g_rest
      assign words_o[i] = len_short ? '0 : data_i[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
  import sd_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       new_cmd_i,
  input  cmd_flags_t flags_i,
  input  logic       card_ready_i,
  input  logic       rsp_valid_i,
  output logic       req_o,
  output logic       accept_o,
  output logic       done_o,
  output cmd_flags_t flags_o,
  output logic       busy_o
);
  seq_state_e state_q, state_d;
  logic       pending_q, pending_d;
  cmd_flags_t flags_q;

  assign req_o    = (state_q == SEQ_IDLE) & pending_q;
  assign accept_o = req_o & card_ready_i;
  assign done_o   = (state_q == SEQ_WAIT) & rsp_valid_i;
  assign busy_o   = pending_q | (state_q == SEQ_WAIT);
  assign flags_o  = flags_q;

  always_comb begin
    state_d = state_q;
    if (accept_o)    state_d = SEQ_WAIT;
    else if (done_o) state_d = SEQ_IDLE;
  end

  // a write in the accept cycle queues a fresh command
  always_comb begin
    pending_d = pending_q;
    if (new_cmd_i)     pending_d = 1'b1;
    else if (accept_o) pending_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_IDLE;
      pending_q <= 1'b0;
      flags_q   <= '0;
    end else begin
      state_q   <= state_d;
      pending_q <= pending_d;
      if (accept_o) flags_q <= flags_i;
    end
  end
endmodule

// File: rtl/sd_cmd_regs.sv
module sd_cmd_regs
  import sd_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RSP_WORDS = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  input  logic                             accept_i,
  input  logic                             done_i,
  input  logic                             fail_i,
  input  logic                             store_i,
  input  logic                             busyw_i,
  input  logic [RSP_WORDS-1:0][DATA_W-1:0] words_i,
  output logic                             new_cmd_o,
  output logic [CMD_W-1:0]                 cmd_o,
  output logic [DATA_W-1:0]                arg_o,
  output logic [STS_W-1:0]                 sts_o,
  output logic                             irq_o
);
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [DATA_W-1:0] arg_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [STS_W-1:0]  sts_q, sts_d;
  logic [RSP_WORDS-1:0][DATA_W-1:0] rsp_q;
  logic wr_cmd, wr_arg, wr_cfg, wr_sts, busy_evt;

  assign wr_cmd    = we_i & (addr_i == ADDR_W'(OFF_CMD));
  assign wr_arg    = we_i & (addr_i == ADDR_W'(OFF_ARG));
  assign wr_cfg    = we_i & (addr_i == ADDR_W'(OFF_CFG));
  assign wr_sts    = we_i & (addr_i == ADDR_W'(OFF_STS));
  assign new_cmd_o = wr_cmd & wdata_i[BIT_NEW];
  assign busy_evt  = done_i & !fail_i & busyw_i & cfg_q[CFG_BUSYIE];

  always_comb begin
    cmd_d = wr_cmd ? wdata_i[CMD_W-1:0] : cmd_q;
    if (accept_i && !wr_cmd) cmd_d[BIT_NEW] = 1'b0;
    if (done_i && fail_i)    cmd_d[BIT_FAIL] = 1'b1;
  end

  // set events win over a clear in the same cycle
  always_comb begin
    sts_d = sts_q;
    if (wr_sts)           sts_d = sts_q & ~wdata_i[STS_W-1:0];
    if (done_i && fail_i) sts_d[STS_TOUT] = 1'b1;
    if (busy_evt)         sts_d[STS_BUSYIRQ] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      arg_q <= '0;
      cfg_q <= '0;
      sts_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      sts_q <= sts_d;
      if (wr_arg) arg_q <= wdata_i;
      if (wr_cfg) cfg_q <= wdata_i[CFG_W-1:0];
    end
  end

  for (genvar i = 0; i < RSP_WORDS; i++) begin : g_rsp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                rsp_q[i] <= '0;
      else if (done_i && store_i) rsp_q[i] <= words_i[i];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_CMD)) rdata_o = DATA_W'(cmd_q);
    if (addr_i == ADDR_W'(OFF_ARG)) rdata_o = arg_q;
    if (addr_i == ADDR_W'(OFF_STS)) rdata_o = DATA_W'(sts_q);
    if (addr_i == ADDR_W'(OFF_CFG)) rdata_o = DATA_W'(cfg_q);
    for (int i = 0; i < RSP_WORDS; i++) begin
      if (addr_i == ADDR_W'(OFF_RSP0 + 8'(4 * i))) rdata_o = rsp_q[i];
    end
  end

  assign cmd_o = cmd_q;
  assign arg_o = arg_q;
  assign sts_o = sts_q;
  assign irq_o = |sts_q[STS_BUSYIRQ:STS_BUSYIRQ-2];
endmodule

// File: rtl/sd_cmd_path.sv
module sd_cmd_path
  import sd_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RSP_WORDS = 4,
  parameter int unsigned LEN_W     = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          reg_we_i,
  input  logic [ADDR_W-1:0]             reg_addr_i,
  input  logic [DATA_W-1:0]             reg_wdata_i,
  output logic [DATA_W-1:0]             reg_rdata_o,
  output logic                          card_req_o,
  input  logic                          card_ready_i,
  output logic [IDX_W-1:0]              card_idx_o,
  output logic [DATA_W-1:0]             card_arg_o,
  input  logic                          card_rsp_valid_i,
  input  logic                          card_rsp_err_i,
  input  logic [LEN_W-1:0]              card_rsp_len_i,
  input  logic [RSP_WORDS*DATA_W-1:0]   card_rsp_data_i,
  output logic                          busy_o,
  output logic                          irq_o
);
  logic                             new_cmd, accept, done, rsp_fail, rsp_store;
  logic [CMD_W-1:0]                 cmd_word;
  logic [STS_W-1:0]                 sts_word;
  logic [DATA_W-1:0]                arg_word;
  cmd_flags_t                       cur_flags, act_flags;
  logic [RSP_WORDS-1:0][DATA_W-1:0] rsp_words;

  assign cur_flags  = '{busyw: cmd_word[BIT_BUSYW], norsp: cmd_word[BIT_NORSP],
                        longr: cmd_word[BIT_LONG]};
  assign card_idx_o = cmd_word[IDX_W-1:0];
  assign card_arg_o = arg_word;

  sd_cmd_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .new_cmd_i    (new_cmd),
    .flags_i      (cur_flags),
    .card_ready_i (card_ready_i),
    .rsp_valid_i  (card_rsp_valid_i),
    .req_o        (card_req_o),
    .accept_o     (accept),
    .done_o       (done),
    .flags_o      (act_flags),
    .busy_o       (busy_o)
  );

  sd_rsp_check #(.DATA_W(DATA_W), .RSP_WORDS(RSP_WORDS), .LEN_W(LEN_W)) u_chk_rsp (
    .flags_i (act_flags),
    .err_i   (card_rsp_err_i),
    .len_i   (card_rsp_len_i),
    .data_i  (card_rsp_data_i),
    .fail_o  (rsp_fail),
    .store_o (rsp_store),
    .words_o (rsp_words)
  );

  sd_cmd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RSP_WORDS(RSP_WORDS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .accept_i  (accept),
    .done_i    (done),
    .fail_i    (rsp_fail),
    .store_i   (rsp_store),
    .busyw_i   (act_flags.busyw),
    .words_i   (rsp_words),
    .new_cmd_o (new_cmd),
    .cmd_o     (cmd_word),
    .arg_o     (arg_word),
    .sts_o     (sts_word),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/sd_cmd_path_chk.sv
module sd_cmd_path_chk
  import sd_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              card_req_o,
  input logic              card_ready_i,
  input logic              card_rsp_valid_i,
  input logic              busy_o,
  input logic              irq_o,
  input logic              done,
  input logic              rsp_fail,
  input logic [CMD_W-1:0]  cmd_word,
  input logic [STS_W-1:0]  sts_word
);
  logic wr_cmd, wr_sts;
  assign wr_cmd = reg_we_i & (reg_addr_i == ADDR_W'(OFF_CMD));
  assign wr_sts = reg_we_i & (reg_addr_i == ADDR_W'(OFF_STS));

  a_r1_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_req_o && card_ready_i && !wr_cmd) |=> !cmd_word[BIT_NEW]);

  a_r2_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_req_o |-> busy_o);

  a_r2_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_req_o && !card_ready_i) |=> card_req_o);

  a_r2_busy_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(card_rsp_valid_i));

  a_r6_fail_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && rsp_fail) |=> (cmd_word[BIT_FAIL] && sts_word[STS_TOUT]));

  a_r8_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done));

  a_r9_w1c_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts && reg_wdata_i[STS_TOUT] && !done) |=> !sts_word[STS_TOUT]);
endmodule

bind sd_cmd_path sd_cmd_path_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .reg_we_i         (reg_we_i),
  .reg_addr_i       (reg_addr_i),
  .reg_wdata_i      (reg_wdata_i),
  .card_req_o       (card_req_o),
  .card_ready_i     (card_ready_i),
  .card_rsp_valid_i (card_rsp_valid_i),
  .busy_o           (busy_o),
  .irq_o            (irq_o),
  .done             (done),
  .rsp_fail         (rsp_fail),
  .cmd_word         (cmd_word),
  .sts_word         (sts_word)
);

// File: tb/tb_sd_cmd_path.sv
module tb_sd_cmd_path;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         reg_we = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         card_req, card_ready = 1'b0;
  logic [5:0]   card_idx;
  logic [31:0]  card_arg;
  logic         rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [4:0]   rsp_len = '0;
  logic [127:0] rsp_data = '0;
  logic         busy, irq;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic [31:0] m_rsp [4];
  logic [10:0] m_sts = '0;
  logic [10:0] m_cfg = '0;

  always #5 clk = ~clk;

  sd_cmd_path dut (
    .clk_i (clk), .rst_ni (rst_ni),
    .reg_we_i (reg_we), .reg_addr_i (reg_addr), .reg_wdata_i (reg_wdata), .reg_rdata_o (reg_rdata),
    .card_req_o (card_req), .card_ready_i (card_ready), .card_idx_o (card_idx), .card_arg_o (card_arg),
    .card_rsp_valid_i (rsp_valid), .card_rsp_err_i (rsp_err), .card_rsp_len_i (rsp_len),
    .card_rsp_data_i (rsp_data), .busy_o (busy), .irq_o (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic bit fails(input logic [15:0] c, input logic [4:0] len, input bit err);
    return err || (!c[10] && (len == 0 || (len == 4 && c[9]) || (len != 4 && len != 16)));
  endfunction

  task automatic check_regs(input string req, input logic [31:0] exp_cmd);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(8'h10 + 8'(4 * i), v);
      chk(req, v, m_rsp[i]);
    end
    rd(8'h20, v); chk(req, v, {21'd0, m_sts});
    rd(8'h00, v); chk(req, v, exp_cmd);
    chk({req, " irq"}, {31'd0, irq}, {31'd0, |m_sts[10:8]});
  endtask

  // full command: request, hold, accept, response, compare
  task automatic do_cmd(input logic [15:0] c, input logic [31:0] arg, input logic [4:0] len,
                        input bit err, input logic [127:0] data, input int hold, input int dly);
    logic [31:0] v;
    bit f;
    wr(8'h04, arg);
    wr(8'h00, {16'd0, c});
    chk("R1 req", {31'd0, card_req}, 32'd1);
    chk("R1 idx", {26'd0, card_idx}, {26'd0, c[5:0]});
    chk("R1 arg", card_arg, arg);
    chk("R2 busy", {31'd0, busy}, 32'd1);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R2 held", {30'd0, card_req, busy}, 32'd3);
    end
    card_ready = 1'b1;
    @(negedge clk);
    card_ready = 1'b0;
    rd(8'h00, v);
    chk("R1 start clear", v, {16'd0, c & 16'h7fff});
    for (int d = 0; d < dly; d++) begin
      @(negedge clk);
      chk("R2 wait", {30'd0, card_req, busy}, 32'd1);
    end
    rsp_valid = 1'b1; rsp_len = len; rsp_err = err; rsp_data = data;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_err = 1'b0;
    f = fails(c, len, err);
    if (f) m_sts[6] = 1'b1;
    else begin
      if (!c[10]) begin
        if (len == 4) begin
          m_rsp[0] = data[127:96]; m_rsp[1] = '0; m_rsp[2] = '0; m_rsp[3] = '0;
        end else begin
          for (int i = 0; i < 4; i++) m_rsp[i] = data[32*i +: 32];
        end
      end
      if (c[11] && m_cfg[10]) m_sts[10] = 1'b1;
    end
    chk("R2 idle", {31'd0, busy}, 32'd0);
    check_regs(f ? "R6 R7 fail" : (c[10] ? "R3" : (len == 4 ? "R4" : "R5")),
               {16'd0, (c & 16'h3fff) | (f ? 16'h4000 : 16'h0)});
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [127:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) m_rsp[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 busy/irq/req", {29'd0, busy, irq, card_req}, 32'd0);
    check_regs("R12", 32'd0);
    rd(8'h04, v); chk("R12 arg", v, 32'd0);
    rd(8'h24, v); chk("R12 cfg", v, 32'd0);

    // R10 map
    wr(8'h24, 32'hffff_ffff);
    rd(8'h24, v); chk("R10 cfg", v, 32'h7ff);
    rd(8'h08, v); chk("R10 unmapped", v, 32'd0);
    rd(8'h40, v); chk("R10 unmapped", v, 32'd0);
    wr(8'h24, 32'h400); m_cfg = 11'h400;

    d = 128'h00112233_44556677_8899aabb_ccddeeff;
    do_cmd(16'h8011, 32'hdead_beef, 5'd4, 0, d, 2, 1);                 // R4
    do_cmd(16'h8202, 32'h1, 5'd16, 0, ~d, 0, 0);                       // R5
    do_cmd(16'h8403, 32'h2, 5'd16, 0, d, 0, 2);                        // R3
    do_cmd(16'h8804, 32'h3, 5'd4, 0, d, 1, 0);                         // R8 busy irq
    chk("R8 irq", {31'd0, irq}, 32'd1);
    do_cmd(16'h8005, 32'h4, 5'd0, 0, d, 0, 0);                         // R6 zero
    do_cmd(16'h8206, 32'h5, 5'd4, 0, d, 0, 0);                         // R6 short while long
    do_cmd(16'h8007, 32'h6, 5'd8, 0, d, 0, 0);                         // R6 odd length

    // R9 clear busy bit only, timeout stays
    wr(8'h20, 32'h400); m_sts[10] = 1'b0;
    check_regs("R9", 32'h4007);
    wr(8'h20, 32'h40); m_sts[6] = 1'b0;
    check_regs("R9", 32'h4007);

    do_cmd(16'h8408, 32'h7, 5'd4, 1, d, 0, 0);                         // R7
    wr(8'h20, 32'h7ff); m_sts = '0;
    wr(8'h24, 32'h0); m_cfg = '0;
    do_cmd(16'h8809, 32'h8, 5'd4, 0, d, 0, 0);                         // R8 disabled
    chk("R8 no irq", {31'd0, irq}, 32'd0);

    // R11 stray response
    rsp_valid = 1'b1; rsp_len = 5'd4; rsp_data = ~d;
    @(negedge clk);
    rsp_valid = 1'b0;
    check_regs("R11", 32'h0809);
    chk("R11 busy", {31'd0, busy}, 32'd0);

    // R2 command written while one is outstanding
    wr(8'h04, 32'h55);
    wr(8'h00, 32'h840a);
    card_ready = 1'b1; @(negedge clk); card_ready = 1'b0;
    wr(8'h00, 32'h800b);
    chk("R2 queued no req", {30'd0, card_req, busy}, 32'd1);
    rsp_valid = 1'b1; rsp_len = 5'd0;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk("R2 next req", {25'd0, card_req, card_idx}, {25'd0, 1'b1, 6'h0b});
    card_ready = 1'b1; @(negedge clk); card_ready = 1'b0;
    rsp_valid = 1'b1; rsp_len = 5'd4; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
    m_rsp[0] = d[127:96]; m_rsp[1] = '0; m_rsp[2] = '0; m_rsp[3] = '0;
    chk("R2 done", {31'd0, busy}, 32'd0);
    check_regs("R4 queued", 32'h000b);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [15:0] c;
      logic [4:0]  len;
      logic [127:0] rd_data;
      if (it % 10 == 0) begin
        m_cfg = ($urandom % 2) ? 11'h400 : 11'h0;
        wr(8'h24, {21'd0, m_cfg});
      end
      if (it % 7 == 3) begin
        v = $urandom & 32'h7ff;
        wr(8'h20, v);
        m_sts = m_sts & ~v[10:0];
      end
      c = 16'h8000 | 16'($urandom & 32'h0e3f);
      case ($urandom % 4)
        0: len = 5'd4;
        1: len = 5'd16;
        2: len = 5'd0;
        default: len = 5'($urandom);
      endcase
      rd_data = {$urandom, $urandom, $urandom, $urandom};
      do_cmd(c, $urandom, len, ($urandom % 8) == 0, rd_data, $urandom % 3, $urandom % 4);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule